// File: doc/BRIEF.md
# Checked Fuse Configuration Loader

After every reset this block copies the contents of a one-time-programmable fuse array into a set of configuration registers. It fetches one fuse word per clock through a strobe-and-address port, where each word arrives one clock after its strobe. While the words stream in, the block runs a 16-bit CRC over the payload words. When the last word has been fetched, it compares that CRC with the checksum held in the final fuse words. A mismatch discards the pass and starts a new read from the first address. The block keeps retrying until a pass matches.

The configuration registers are held in three copies. They are loaded only on clock edges. A commit strobe drives the loading, and that strobe is itself triplicated and voted before any copy acts on it. On every clock each copy reloads from the voted value of all three, so an upset in one copy is overwritten on the next cycle. Until the first good pass, the voted configuration bus shows a parameterised safe pattern. A retry counter reports how many passes were rejected.

Top module: `fuse_cfg_loader`

## Requirements
- R1: One clock edge after reset is released, the block raises `fuse_rd_o` with `fuse_addr_o` = 0, without any external command.
- R2: Within a pass, addresses 0 to NUM_WORDS-1 are strobed on consecutive cycles, one per cycle. `fuse_data_i` is taken in the cycle after each strobe. Every pass begins again at address 0.
- R3: The checksum is computed over words 0 to NUM_WORDS-3, taken in address order and MSB first. It uses polynomial 0x1021, initial value 0xFFFF, no reflection and no final XOR. The stored checksum has its high byte at address NUM_WORDS-2 and its low byte at address NUM_WORDS-1.
- R4: On a matching pass, `load_done_o` rises and `cfg_o` carries payload word k at bits [8k+7:8k]. From then on `fuse_rd_o` stays low and `retry_cnt_o` does not change.
- R5: On a mismatching pass, the data is discarded and `retry_cnt_o` increments by one. A new full pass starts at address 0.
- R6: Until the first matching pass, `cfg_o` equals SAFE_CFG and `load_done_o` is low.
- R7: `retry_cnt_o` is 0 after reset, steps by one per rejected pass and saturates at 255.
- R8: Once `load_done_o` is high, it and `cfg_o` stay constant until the next reset.
- R9: Reset is synchronous and active low. It returns `cfg_o` to SAFE_CFG and clears `load_done_o` and the retry count, even in the middle of a pass. A fresh load starts when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| fuse_rd_o | output | 1 | Fuse word read strobe |
| fuse_addr_o | output | ADDR_W (5) | Fuse word address |
| fuse_data_i | input | WORD_W (8) | Fuse word, valid the cycle after the strobe |
| cfg_o | output | CFG_W (240) | Voted configuration bus |
| load_done_o | output | 1 | Voted flag, high after a matching pass |
| retry_cnt_o | output | RETRY_W (8) | Rejected-pass count, saturating |

## Verification
The assertions check several properties on every cycle:
- strobed addresses run without gaps, and each run of strobes starts at 0;
- the bus holds the safe pattern while loading is incomplete;
- the done flag and the configuration stay frozen once set;
- the retry count only steps by one, and stops at its ceiling;
- reads stop after completion.

Three properties can only be shown by the bench's scenarios, because they depend on the fuse contents:
- the checksum arithmetic and the byte order of the stored checksum, so that only a correct image is accepted;
- the number of passes that corrupted images cost;
- that the loaded bus matches the image byte for byte.

// File: rtl/fuse_cfg_pkg.sv
package fuse_cfg_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_ISSUE = 2'd1,
        LD_DRAIN = 2'd2,
        LD_DONE  = 2'd3
    } ld_state_e;

endpackage

// File: rtl/fuse_crc_step.sv
// One word of an MSB-first, non-reflected CRC, unrolled over DATA_W bits.
module fuse_crc_step #(
    parameter int               DATA_W = 8,
    parameter int               CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY   = 16'h1021
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);

    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = crc_i;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            fb  = acc[CRC_W-1] ^ data_i[b];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_o = acc;
    end

endmodule

// File: rtl/fuse_maj3.sv
// Bitwise two-out-of-three voter.
module fuse_maj3 #(
    parameter int W = 1
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] y_o
);

    always_comb begin
        y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end

endmodule

// File: rtl/fuse_load_seq.sv
// Read sequencer: strobes the fuse words, checks the CRC, stages the payload
// and emits a one-cycle commit pulse on a matching pass.
module fuse_load_seq
    import fuse_cfg_pkg::*;
#(
    parameter int               NUM_WORDS = 32,
    parameter int               WORD_W    = 8,
    parameter int               CRC_W     = 16,
    parameter logic [CRC_W-1:0] CRC_POLY  = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
    parameter int               RETRY_W   = 8,
    localparam int              ADDR_W    = $clog2(NUM_WORDS),
    localparam int              CRC_WORDS = CRC_W / WORD_W,
    localparam int              PAY_WORDS = NUM_WORDS - CRC_WORDS,
    localparam int              CFG_W     = PAY_WORDS * WORD_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    output logic               fuse_rd_o,
    output logic [ADDR_W-1:0]  fuse_addr_o,
    input  logic [WORD_W-1:0]  fuse_data_i,
    output logic [CFG_W-1:0]   stage_o,
    output logic               commit_o,
    output logic [RETRY_W-1:0] retry_cnt_o
);

    localparam int               REF_W     = CRC_W - WORD_W;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

    typedef struct packed {
        ld_state_e          st;
        logic [ADDR_W-1:0]  rd_addr;
        logic               cap_vld;
        logic [ADDR_W-1:0]  cap_addr;
        logic [CRC_W-1:0]   crc;
        logic [REF_W-1:0]   crc_ref;
        logic [CFG_W-1:0]   stage;
        logic [RETRY_W-1:0] retries;
        logic               commit;
    } seq_regs_t;

    seq_regs_t        seq_d, seq_q;
    logic [CRC_W-1:0] crc_next;
    logic [CRC_W-1:0] stored_crc;

    fuse_crc_step #(
        .DATA_W (WORD_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY)
    ) u_crc (
        .crc_i  (seq_q.crc),
        .data_i (fuse_data_i),
        .crc_o  (crc_next)
    );

    assign stored_crc = {seq_q.crc_ref, fuse_data_i};

    always_comb begin
        seq_d          = seq_q;
        seq_d.commit   = 1'b0;
        seq_d.cap_vld  = (seq_q.st == LD_ISSUE);
        seq_d.cap_addr = seq_q.rd_addr;

        unique case (seq_q.st)
            LD_IDLE: begin
                seq_d.st      = LD_ISSUE;
                seq_d.rd_addr = '0;
                seq_d.crc     = CRC_INIT;
            end
            LD_ISSUE: begin
                seq_d.rd_addr = seq_q.rd_addr + 1'b1;
                if (seq_q.rd_addr == LAST_ADDR) begin
                    seq_d.st = LD_DRAIN;
                end
            end
            LD_DRAIN: begin
            end
            LD_DONE: begin
            end
            default: begin
                seq_d.st = LD_IDLE;
            end
        endcase

        if (seq_q.cap_vld) begin
            if (int'(seq_q.cap_addr) < PAY_WORDS) begin
                seq_d.crc = crc_next;
                seq_d.stage[int'(seq_q.cap_addr) * WORD_W +: WORD_W] = fuse_data_i;
            end else begin
                seq_d.crc_ref = REF_W'({seq_q.crc_ref, fuse_data_i});
            end
            if (seq_q.cap_addr == LAST_ADDR) begin
                if (stored_crc == seq_q.crc) begin
                    seq_d.st     = LD_DONE;
                    seq_d.commit = 1'b1;
                end else begin
                    seq_d.st      = LD_ISSUE;
                    seq_d.rd_addr = '0;
                    seq_d.crc     = CRC_INIT;
                    if (seq_q.retries != '1) begin
                        seq_d.retries = seq_q.retries + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q     <= '0;
            seq_q.crc <= CRC_INIT;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fuse_rd_o   = (seq_q.st == LD_ISSUE);
    assign fuse_addr_o = seq_q.rd_addr;
    assign stage_o     = seq_q.stage;
    assign commit_o    = seq_q.commit;
    assign retry_cnt_o = seq_q.retries;

endmodule

// File: rtl/fuse_tmr_cfg.sv
// Three synchronously loaded copies of the configuration, each refreshed
// from the voted value every cycle; the commit strobe is voted before use.
module fuse_tmr_cfg #(
    parameter int               CFG_W    = 240,
    parameter logic [CFG_W-1:0] SAFE_CFG = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             commit_i,
    input  logic [CFG_W-1:0] stage_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic             done_o
);

    localparam int COPIES = 3;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             done;
        logic             commit;
    } copy_t;

    logic             commit_v;
    logic             done_v;
    logic [CFG_W-1:0] cfg_v;

    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        copy_t cp_d, cp_q;

        always_comb begin
            cp_d.commit = commit_i;
            cp_d.cfg    = commit_v ? stage_i : cfg_v;
            cp_d.done   = commit_v | done_v;
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                cp_q.cfg    <= SAFE_CFG;
                cp_q.done   <= 1'b0;
                cp_q.commit <= 1'b0;
            end else begin
                cp_q <= cp_d;
            end
        end
    end

    fuse_maj3 #(.W(1)) u_vote_commit (
        .a_i (g_copy[0].cp_q.commit),
        .b_i (g_copy[1].cp_q.commit),
        .c_i (g_copy[2].cp_q.commit),
        .y_o (commit_v)
    );

    fuse_maj3 #(.W(1)) u_vote_done (
        .a_i (g_copy[0].cp_q.done),
        .b_i (g_copy[1].cp_q.done),
        .c_i (g_copy[2].cp_q.done),
        .y_o (done_v)
    );

    fuse_maj3 #(.W(CFG_W)) u_vote_cfg (
        .a_i (g_copy[0].cp_q.cfg),
        .b_i (g_copy[1].cp_q.cfg),
        .c_i (g_copy[2].cp_q.cfg),
        .y_o (cfg_v)
    );

    assign cfg_o  = cfg_v;
    assign done_o = done_v;

endmodule

// File: rtl/fuse_cfg_loader.sv
module fuse_cfg_loader #(
    parameter int               NUM_WORDS = 32,
    parameter int               WORD_W    = 8,
    parameter int               CRC_W     = 16,
    parameter logic [CRC_W-1:0] CRC_POLY  = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
    parameter int               RETRY_W   = 8,
    parameter logic [(NUM_WORDS - CRC_W / WORD_W) * WORD_W - 1:0] SAFE_CFG = '0,
    localparam int              ADDR_W    = $clog2(NUM_WORDS),
    localparam int              CFG_W     = (NUM_WORDS - CRC_W / WORD_W) * WORD_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    output logic               fuse_rd_o,
    output logic [ADDR_W-1:0]  fuse_addr_o,
    input  logic [WORD_W-1:0]  fuse_data_i,
    output logic [CFG_W-1:0]   cfg_o,
    output logic               load_done_o,
    output logic [RETRY_W-1:0] retry_cnt_o
);

    logic [CFG_W-1:0] stage;
    logic             commit;

    fuse_load_seq #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .CRC_W     (CRC_W),
        .CRC_POLY  (CRC_POLY),
        .CRC_INIT  (CRC_INIT),
        .RETRY_W   (RETRY_W)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fuse_rd_o   (fuse_rd_o),
        .fuse_addr_o (fuse_addr_o),
        .fuse_data_i (fuse_data_i),
        .stage_o     (stage),
        .commit_o    (commit),
        .retry_cnt_o (retry_cnt_o)
    );

    fuse_tmr_cfg #(
        .CFG_W    (CFG_W),
        .SAFE_CFG (SAFE_CFG)
    ) u_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .commit_i (commit),
        .stage_i  (stage),
        .cfg_o    (cfg_o),
        .done_o   (load_done_o)
    );

endmodule

// File: rtl/fuse_cfg_loader_chk.sv
module fuse_cfg_loader_chk #(
    parameter int               ADDR_W   = 5,
    parameter int               CFG_W    = 240,
    parameter int               RETRY_W  = 8,
    parameter logic [CFG_W-1:0] SAFE_CFG = '0
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               fuse_rd_o,
    input logic [ADDR_W-1:0]  fuse_addr_o,
    input logic [CFG_W-1:0]   cfg_o,
    input logic               load_done_o,
    input logic [RETRY_W-1:0] retry_cnt_o
);

    assert_pass_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fuse_rd_o) |-> fuse_addr_o == '0);

    assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fuse_rd_o && $past(fuse_rd_o) |-> fuse_addr_o == ADDR_W'($past(fuse_addr_o) + 1'b1));

    assert_reads_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_done_o |-> !fuse_rd_o);

    assert_retry_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_done_o |-> $stable(retry_cnt_o));

    assert_safe_bus_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_done_o |-> cfg_o == SAFE_CFG);

    assert_retry_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retry_cnt_o != $past(retry_cnt_o) |-> retry_cnt_o == RETRY_W'($past(retry_cnt_o) + 1'b1));

    assert_retry_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        &retry_cnt_o |=> &retry_cnt_o);

    assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_done_o |=> load_done_o && $stable(cfg_o));

endmodule

bind fuse_cfg_loader fuse_cfg_loader_chk #(
    .ADDR_W   (ADDR_W),
    .CFG_W    (CFG_W),
    .RETRY_W  (RETRY_W),
    .SAFE_CFG (SAFE_CFG)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fuse_rd_o   (fuse_rd_o),
    .fuse_addr_o (fuse_addr_o),
    .cfg_o       (cfg_o),
    .load_done_o (load_done_o),
    .retry_cnt_o (retry_cnt_o)
);

// File: tb/fuse_cfg_loader_tb.sv
module fuse_cfg_loader_tb_top;

    localparam int NW    = 32;
    localparam int PW    = 30;
    localparam int CW    = PW * 8;
    localparam logic [CW-1:0] SAFE = {PW{8'h5A}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fuse_rd;
    logic [4:0]    fuse_addr;
    logic [7:0]    fuse_data = '0;
    logic [CW-1:0] cfg;
    logic          load_done;
    logic [7:0]    retry_cnt;

    always #4 clk = ~clk;

    fuse_cfg_loader #(.SAFE_CFG(SAFE)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .fuse_rd_o   (fuse_rd),
        .fuse_addr_o (fuse_addr),
        .fuse_data_i (fuse_data),
        .cfg_o       (cfg),
        .load_done_o (load_done),
        .retry_cnt_o (retry_cnt)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    logic [7:0] img [NW];
    int   bad_left = 0;
    int   bad_addr = 0;
    logic [7:0] bad_mask = 8'h01;
    int   reads = 0;
    int   mon_err = 0;
    int   safe_err = 0;
    logic prev_rd = 1'b0;
    logic [4:0] prev_addr = '0;

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {img[i], 8'h00};
            for (int k = 0; k < 8; k++) begin
                if (c[15]) c = (c << 1) ^ 16'h1021;
                else       c = c << 1;
            end
        end
        return c;
    endfunction

    function automatic logic [CW-1:0] ref_cfg();
        logic [CW-1:0] v;
        for (int i = 0; i < PW; i++) v[i*8 +: 8] = img[i];
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // fuse array model: data valid the cycle after the strobe
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_rd = 1'b0;
        end else begin
            if (fuse_rd) begin
                logic [7:0] d;
                if (prev_rd) begin
                    if (fuse_addr != prev_addr + 5'd1) mon_err++;
                end else if (fuse_addr != 5'd0) begin
                    mon_err++;
                end
                d = img[fuse_addr];
                if (bad_left > 0 && int'(fuse_addr) == bad_addr) d = d ^ bad_mask;
                if (bad_left > 0 && fuse_addr == 5'd31) bad_left--;
                fuse_data <= d;
                reads++;
            end
            prev_rd   = fuse_rd;
            prev_addr = fuse_addr;
        end
        if (cyc == 150000) begin
            n_fails++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic fill_random();
        for (int i = 0; i < PW; i++) img[i] = 8'($urandom);
    endtask

    task automatic seal();
        logic [15:0] c;
        c = ref_crc(PW);
        img[30] = c[15:8];
        img[31] = c[7:0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: synchronous reset state
        check(load_done == 1'b0, "R9", "done in reset", 256'(load_done), 0);
        check(cfg == SAFE, "R9", "cfg in reset", 256'(cfg), 256'(SAFE));
        check(retry_cnt == 8'd0, "R7", "retries in reset", 256'(retry_cnt), 0);
        check(fuse_rd == 1'b0, "R9", "strobe in reset", 256'(fuse_rd), 0);
        reads = 0; mon_err = 0; safe_err = 0;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: automatic start at address 0
        check(fuse_rd == 1'b1 && fuse_addr == 5'd0, "R1", "first strobe",
              256'({fuse_rd, fuse_addr}), 256'({1'b1, 5'd0}));
    endtask

    task automatic wait_done(input int limit, output bit ok);
        int n = 0;
        while (!load_done && n < limit) begin
            if (cfg != SAFE) safe_err++;
            @(negedge clk);
            n++;
        end
        ok = load_done;
    endtask

    task automatic run_case(input int passes_bad, input string tag);
        bit ok;
        int r0;
        int exp_retry;
        logic [CW-1:0] c0;
        seal();
        bad_addr = $urandom % NW;
        bad_mask = 8'(1) << ($urandom % 8);
        bad_left = passes_bad;
        do_reset();
        wait_done(40 * (passes_bad + 2), ok);
        exp_retry = passes_bad > 255 ? 255 : passes_bad;
        check(ok, "R4", {tag, " done"}, 256'(load_done), 1);
        check(safe_err == 0, "R6", {tag, " safe bus before done"}, safe_err, 0);
        check(cfg == ref_cfg(), "R3", {tag, " cfg image"}, 256'(cfg), 256'(ref_cfg()));
        check(int'(retry_cnt) == exp_retry, "R5", {tag, " retry count"}, retry_cnt, exp_retry);
        check(reads == NW * (passes_bad + 1), "R5", {tag, " fuse reads"}, reads, NW * (passes_bad + 1));
        check(mon_err == 0, "R2", {tag, " address order"}, mon_err, 0);
        r0 = reads;
        c0 = cfg;
        repeat (20) @(negedge clk);
        check(reads == r0, "R4", {tag, " reads after done"}, reads, r0);
        check(cfg == c0 && load_done, "R8", {tag, " hold after done"}, 256'(cfg), 256'(c0));
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < NW; i++) img[i] = '0;

        // directed: all-zero payload, clean image
        for (int i = 0; i < PW; i++) img[i] = 8'h00;
        run_case(0, "zero payload");
        // directed: all-ones payload, two bad passes
        for (int i = 0; i < PW; i++) img[i] = 8'hFF;
        run_case(2, "ones payload");

        // random payloads and random numbers of rejected passes (R5)
        for (int t = 0; t < 6; t++) begin
            fill_random();
            run_case(int'($urandom % 5), "random");
        end

        // R9: reset in the middle of a pass, then a clean load
        fill_random();
        seal();
        bad_left = 0;
        do_reset();
        repeat (5 + ($urandom % 20)) @(negedge clk);
        run_case(0, "after mid-pass reset");

        // R7: saturation of the retry counter
        fill_random();
        run_case(300, "saturation");

        summary();
        $finish;
    end

endmodule